// File: doc/BRIEF.md
# Firmware image checker and loader

This block takes in a coprocessor firmware image as a stream of 32-bit words with a valid/ready handshake. A start pulse comes with the total image length in bytes. The first word is a magic value. It sets the byte order for the whole image: from then on every word of a big-endian image is byte-reversed before it is used.

The five header words are magic, sequence, version, instruction-section byte size and data-section byte size. After the fifth header word the block checks the two section sizes against each other, against the total length and against the memory depths. It then zero-fills both target memories over the declared sizes. Next it stores the instruction words into one word-addressed memory and the data words into another, in that order. It keeps a running wrapping sum the whole time and compares it with the trailing checksum word. At the end it raises done together with either ok or an error code. The code holds until the next start pulse. After an error the block accepts no more words and writes nothing.

Top module: `fw_image_loader`

## Requirements
- R1: The first word after start selects the byte order. 32'hfe0101fe gives little endian (big_endian_o=0) and 32'hfe1010fe gives big endian (big_endian_o=1). Any other value ends the image at once with done_o=1 and err_o=1.
- R2: For a big-endian image every word is byte-reversed (bits [7:0] become [31:24]) before it is stored, summed or compared. For a little-endian image words are used unchanged.
- R3: Header words arrive in this order: magic, sequence, version, instruction byte size, data byte size. After the header, seg_count_o holds bits [31:16] and seg_index_o holds bits [15:0] of the converted sequence word.
- R4: If either section byte size has a nonzero value in bits [1:0], the image ends after the header with err_o=2.
- R5: If 20 + instruction size + data size + 4 differs from the byte length given at start, the image ends after the header with err_o=2. The size checks of R4 and R5 are applied before R6.
- R6: If a section holds more words than its memory depth (IMEM_DEPTH or DMEM_DEPTH), the image ends after the header with err_o=4.
- R7: Before the first section word is accepted, the block writes zero to instruction addresses 0..I-1 and to data addresses 0..D-1, where I and D are the declared word counts. It writes to no other address and keeps ready_o low while it does so.
- R8: Section word k of the instruction section is written to instruction address k. After that, section word k of the data section is written to data address k. Each write happens in the cycle in which the word is accepted.
- R9: The checksum is the 32-bit wrapping sum of the five converted header words and every converted section word. If the final word matches it, done_o=1, ok_o=1 and err_o=0. Otherwise done_o=1, ok_o=0 and err_o=3.
- R10: Once done_o is set, done_o, ok_o and err_o hold until the next start_i, and no memory write occurs. A header error produces no memory write at all.
- R11: A word is taken only in a cycle with valid_i and ready_o both high, so idle cycles on valid_i have no effect. ready_o is low after reset, during zero-fill and while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new image; restarts from any state |
| total_len_i | input | 32 | Image length in bytes, sampled with start_i |
| data_i | input | 32 | Stream word |
| valid_i | input | 1 | Stream word valid |
| ready_o | output | 1 | Block can take a word |
| imem_we_o | output | 1 | Instruction memory write enable |
| imem_addr_o | output | IAW (6) | Instruction memory word address |
| imem_data_o | output | 32 | Instruction memory write data |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_addr_o | output | DAW (6) | Data memory word address |
| dmem_data_o | output | 32 | Data memory write data |
| done_o | output | 1 | Image finished, successfully or not |
| ok_o | output | 1 | Image loaded and checksum matched |
| err_o | output | 3 | 0 none, 1 magic, 2 size, 3 checksum, 4 range |
| big_endian_o | output | 1 | Byte order of the current image |
| seg_count_o | output | 16 | Total segment count from the sequence word |
| seg_index_o | output | 16 | This segment's index from the sequence word |

## Verification
Memory writes are combinational on the accept, so they show in the same cycle as the handshake. The bench drives just after a rising edge and logs writes at the falling edge of that cycle. The done, ok and error outputs, the byte-order flag and the segment fields are registered, so they are due one edge after the word that decides them. The bench reads them at the falling edge that follows. Zero-fill starts on the edge that takes the fifth header word and shows as writes while ready_o is low. The bench checks that each address was filled before its data write, and that nothing is written once done is set.

// File: rtl/fw_load_pkg.sv
package fw_load_pkg;
  localparam logic [31:0] MAGIC_LE   = 32'hfe01_01fe;
  localparam logic [31:0] MAGIC_BE   = 32'hfe10_10fe;
  localparam int unsigned HDR_WORDS  = 5;
  localparam int unsigned HDR_BYTES  = 4 * HDR_WORDS;
  localparam int unsigned TAIL_BYTES = 4;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_MAGIC = 3'd1,
    ERR_SIZE  = 3'd2,
    ERR_CSUM  = 3'd3,
    ERR_RANGE = 3'd4
  } fw_err_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_CLEAR, ST_ISEC, ST_DSEC, ST_CSUM, ST_DONE
  } fw_state_e;
endpackage

// File: rtl/fw_byte_order.sv
module fw_byte_order #(
  parameter int unsigned BYTES = 4
) (
  input  logic                 swap_i,
  input  logic [8*BYTES-1:0]   word_i,
  output logic [8*BYTES-1:0]   word_o
);
  logic [8*BYTES-1:0] rev;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign rev[8*b +: 8] = word_i[8*(BYTES-1-b) +: 8];
  end

  assign word_o = swap_i ? rev : word_i;
endmodule

// File: rtl/fw_size_check.sv
module fw_size_check
  import fw_load_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 64,
  parameter int unsigned DMEM_DEPTH = 64,
  parameter int unsigned CW         = 7
) (
  input  logic [31:0]   isize_i,
  input  logic [31:0]   dsize_i,
  input  logic [31:0]   total_len_i,
  output fw_err_e       err_o,
  output logic [CW-1:0] iwords_o,
  output logic [CW-1:0] dwords_o
);
  logic [33:0] need;
  logic        misaligned, len_bad, i_over, d_over;

  assign need       = {2'b00, isize_i} + {2'b00, dsize_i} + 34'(HDR_BYTES + TAIL_BYTES);
  assign misaligned = (|isize_i[1:0]) | (|dsize_i[1:0]);
  assign len_bad    = need != {2'b00, total_len_i};
  assign i_over     = {2'b00, isize_i[31:2]} > 32'(IMEM_DEPTH);
  assign d_over     = {2'b00, dsize_i[31:2]} > 32'(DMEM_DEPTH);

  always_comb begin
    if (misaligned || len_bad) err_o = ERR_SIZE;
    else if (i_over || d_over) err_o = ERR_RANGE;
    else                       err_o = ERR_NONE;
  end

  assign iwords_o = isize_i[CW+1:2];
  assign dwords_o = dsize_i[CW+1:2];
endmodule

// File: rtl/fw_sum_acc.sv
module fw_sum_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         add_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_o <= '0;
    else if (clr_i) sum_o <= '0;
    else if (add_i) sum_o <= sum_o + word_i;
  end
endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
  import fw_load_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 64,
  parameter int unsigned DMEM_DEPTH = 64,
  localparam int unsigned IAW = $clog2(IMEM_DEPTH),
  localparam int unsigned DAW = $clog2(DMEM_DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [31:0]    total_len_i,
  input  logic [31:0]    data_i,
  input  logic           valid_i,
  output logic           ready_o,
  output logic           imem_we_o,
  output logic [IAW-1:0] imem_addr_o,
  output logic [31:0]    imem_data_o,
  output logic           dmem_we_o,
  output logic [DAW-1:0] dmem_addr_o,
  output logic [31:0]    dmem_data_o,
  output logic           done_o,
  output logic           ok_o,
  output logic [2:0]     err_o,
  output logic           big_endian_o,
  output logic [15:0]    seg_count_o,
  output logic [15:0]    seg_index_o
);
  localparam int unsigned ICW = $clog2(IMEM_DEPTH + 1);
  localparam int unsigned DCW = $clog2(DMEM_DEPTH + 1);
  localparam int unsigned CW  = (ICW > DCW) ? ICW : DCW;

  fw_state_e      st_q;
  logic [2:0]     hdr_idx_q;
  logic [31:0]    len_q, isize_q;
  logic [CW-1:0]  cnt_q, iw_q, dw_q, clr_max;
  logic           big_q, big_sel, acc, done_q, ok_q, clr_last;
  fw_err_e        err_q, sz_err;
  logic [CW-1:0]  sz_iw, sz_dw;
  logic [31:0]    conv, sum;
  logic [15:0]    seg_cnt_q, seg_idx_q;
  fw_state_e      sec_first;

  assign ready_o = (st_q == ST_HDR) || (st_q == ST_ISEC) ||
                   (st_q == ST_DSEC) || (st_q == ST_CSUM);
  assign acc     = valid_i && ready_o;

  // magic decides the order of its own word; later words use the stored flag
  assign big_sel = (st_q == ST_HDR && hdr_idx_q == 3'd0) ? (data_i == MAGIC_BE) : big_q;

  fw_byte_order #(.BYTES(4)) u_order (
    .swap_i (big_sel),
    .word_i (data_i),
    .word_o (conv)
  );

  fw_size_check #(
    .IMEM_DEPTH (IMEM_DEPTH),
    .DMEM_DEPTH (DMEM_DEPTH),
    .CW         (CW)
  ) u_size (
    .isize_i     (isize_q),
    .dsize_i     (conv),
    .total_len_i (len_q),
    .err_o       (sz_err),
    .iwords_o    (sz_iw),
    .dwords_o    (sz_dw)
  );

  fw_sum_acc #(.W(32)) u_sum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .add_i  (acc && (st_q == ST_HDR || st_q == ST_ISEC || st_q == ST_DSEC)),
    .word_i (conv),
    .sum_o  (sum)
  );

  assign clr_max   = (iw_q > dw_q) ? iw_q : dw_q;
  assign clr_last  = cnt_q == clr_max - CW'(1);
  assign sec_first = (iw_q != '0) ? ST_ISEC : (dw_q != '0) ? ST_DSEC : ST_CSUM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      hdr_idx_q <= '0;
      len_q     <= '0;
      isize_q   <= '0;
      cnt_q     <= '0;
      iw_q      <= '0;
      dw_q      <= '0;
      big_q     <= 1'b0;
      err_q     <= ERR_NONE;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      seg_cnt_q <= '0;
      seg_idx_q <= '0;
    end else if (start_i) begin
      st_q      <= ST_HDR;
      hdr_idx_q <= '0;
      cnt_q     <= '0;
      len_q     <= total_len_i;
      err_q     <= ERR_NONE;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_HDR: if (acc) begin
          hdr_idx_q <= hdr_idx_q + 3'd1;
          case (hdr_idx_q)
            3'd0: begin
              if (data_i == MAGIC_LE || data_i == MAGIC_BE) begin
                big_q <= big_sel;
              end else begin
                err_q  <= ERR_MAGIC;
                done_q <= 1'b1;
                st_q   <= ST_DONE;
              end
            end
            3'd1: begin
              seg_cnt_q <= conv[31:16];
              seg_idx_q <= conv[15:0];
            end
            3'd3: isize_q <= conv;
            3'd4: begin
              if (sz_err != ERR_NONE) begin
                err_q  <= sz_err;
                done_q <= 1'b1;
                st_q   <= ST_DONE;
              end else begin
                iw_q  <= sz_iw;
                dw_q  <= sz_dw;
                cnt_q <= '0;
                st_q  <= (sz_iw != '0 || sz_dw != '0) ? ST_CLEAR : ST_CSUM;
              end
            end
            default: ;
          endcase
        end
        ST_CLEAR: begin
          if (clr_last) begin
            cnt_q <= '0;
            st_q  <= sec_first;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_ISEC: if (acc) begin
          if (cnt_q == iw_q - CW'(1)) begin
            cnt_q <= '0;
            st_q  <= (dw_q != '0) ? ST_DSEC : ST_CSUM;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_DSEC: if (acc) begin
          if (cnt_q == dw_q - CW'(1)) begin
            cnt_q <= '0;
            st_q  <= ST_CSUM;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_CSUM: if (acc) begin
          done_q <= 1'b1;
          st_q   <= ST_DONE;
          if (conv == sum) ok_q  <= 1'b1;
          else             err_q <= ERR_CSUM;
        end
        default: ;
      endcase
    end
  end

  assign imem_we_o   = ((st_q == ST_CLEAR) && (cnt_q < iw_q)) || ((st_q == ST_ISEC) && acc);
  assign imem_addr_o = cnt_q[IAW-1:0];
  assign imem_data_o = (st_q == ST_ISEC) ? conv : 32'd0;
  assign dmem_we_o   = ((st_q == ST_CLEAR) && (cnt_q < dw_q)) || ((st_q == ST_DSEC) && acc);
  assign dmem_addr_o = cnt_q[DAW-1:0];
  assign dmem_data_o = (st_q == ST_DSEC) ? conv : 32'd0;

  assign done_o       = done_q;
  assign ok_o         = ok_q;
  assign err_o        = err_q;
  assign big_endian_o = big_q;
  assign seg_count_o  = seg_cnt_q;
  assign seg_index_o  = seg_idx_q;

  p_done_stalls_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);
  p_err_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 3'd0) |-> (!imem_we_o && !dmem_we_o));
  p_err_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(err_o) && $stable(ok_o)));
  p_ok_clean_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> (done_o && err_o == 3'd0));
  p_iaddr_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_we_o |-> (CW'(imem_addr_o) < iw_q));
  p_daddr_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (CW'(dmem_addr_o) < dw_q));
endmodule

// File: tb/fw_image_loader_test.sv
module fw_image_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int MAXW       = 200;

  logic        clk = 1'b0;
  logic        rst_n, start, valid;
  logic [31:0] total_len, data;
  logic        ready, imem_we, dmem_we, done, ok, big_endian;
  logic [5:0]  imem_addr, dmem_addr;
  logic [31:0] imem_data, dmem_data;
  logic [2:0]  err;
  logic [15:0] seg_count, seg_index;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_image_loader #(.IMEM_DEPTH(DEPTH), .DMEM_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .total_len_i(total_len),
    .data_i(data), .valid_i(valid), .ready_o(ready),
    .imem_we_o(imem_we), .imem_addr_o(imem_addr), .imem_data_o(imem_data),
    .dmem_we_o(dmem_we), .dmem_addr_o(dmem_addr), .dmem_data_o(dmem_data),
    .done_o(done), .ok_o(ok), .err_o(err), .big_endian_o(big_endian),
    .seg_count_o(seg_count), .seg_index_o(seg_index)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] imem_m [DEPTH];
  logic [31:0] dmem_m [DEPTH];
  bit          iclr [DEPTH];
  bit          dclr [DEPTH];
  int bad_clear, bad_order, late_wr, n_wr, exp_iw, exp_dw;
  logic [31:0] img   [MAXW];
  logic [31:0] ivals [DEPTH+1];
  logic [31:0] dvals [DEPTH+1];

  task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // write log at the falling edge: writes are combinational on the accept
  always @(negedge clk) if (rst_n) begin
    if (imem_we) begin
      n_wr++;
      if (done) late_wr++;
      if (!ready) begin
        if (imem_data != 0 || int'(imem_addr) >= exp_iw) bad_clear++;
        iclr[imem_addr] = 1'b1;
      end else begin
        if (!iclr[imem_addr]) bad_order++;
        imem_m[imem_addr] = imem_data;
      end
    end
    if (dmem_we) begin
      n_wr++;
      if (done) late_wr++;
      if (!ready) begin
        if (dmem_data != 0 || int'(dmem_addr) >= exp_dw) bad_clear++;
        dclr[dmem_addr] = 1'b1;
      end else begin
        if (!dclr[dmem_addr]) bad_order++;
        dmem_m[dmem_addr] = dmem_data;
      end
    end
  end

  // mode: 0 good, 1 bad magic, 2 misaligned, 3 length, 4 range, 5 checksum
  task automatic run_image(input bit big, input int iw, input int dw, input int mode, input bit bubbles);
    logic [31:0] hdr [5];
    logic [31:0] sum, len, isz, dsz, v;
    int n, exp_err, miss, bad;
    string req;
    isz = 32'(iw * 4);
    dsz = 32'(dw * 4);
    if (mode == 2) dsz = dsz + 32'd2;
    hdr[0] = (mode == 1) ? 32'h1234_5678 : (big ? 32'hfe10_10fe : 32'hfe01_01fe);
    hdr[1] = $urandom;
    hdr[2] = $urandom;
    hdr[3] = isz;
    hdr[4] = dsz;
    n = 0; sum = 0;
    for (int h = 0; h < 5; h++) begin img[n] = hdr[h]; n++; sum += hdr[h]; end
    for (int i = 0; i < iw; i++) begin v = $urandom; ivals[i] = v; sum += v; img[n] = v; n++; end
    for (int i = 0; i < dw; i++) begin v = $urandom; dvals[i] = v; sum += v; img[n] = v; n++; end
    img[n] = (mode == 5) ? sum + 32'd1 : sum; n++;
    len = 32'd24 + isz + dsz;
    if (mode == 3) len = len + 32'd4;
    if (big) for (int k = 0; k < n; k++) img[k] = swap32(img[k]);
    case (mode)
      0: begin exp_err = 0; req = "R9"; end
      1: begin exp_err = 1; req = "R1"; end
      2: begin exp_err = 2; req = "R4"; end
      3: begin exp_err = 2; req = "R5"; end
      4: begin exp_err = 4; req = "R6"; end
      default: begin exp_err = 3; req = "R9"; end
    endcase
    for (int i = 0; i < DEPTH; i++) begin
      imem_m[i] = 32'hA5A5_A5A5; dmem_m[i] = 32'hA5A5_A5A5; iclr[i] = 0; dclr[i] = 0;
    end
    bad_clear = 0; bad_order = 0; late_wr = 0; n_wr = 0; exp_iw = iw; exp_dw = dw;

    @(posedge clk); #1; start = 1; total_len = len;
    @(posedge clk); #1; start = 0;
    for (int k = 0; k < n; k++) begin
      if (done) break;
      if (bubbles && $urandom_range(0, 3) == 0) begin valid = 0; @(posedge clk); #1; end
      valid = 1; data = img[k];
      @(negedge clk);
      while (!ready && !done) @(negedge clk);
      if (!ready) break;
      @(posedge clk); #1;
    end
    valid = 0;
    @(negedge clk);

    chk(done == 1'b1, "R10 done raised", 32'(done), 1);
    chk(int'(err) == exp_err, {req, " error code"}, 32'(err), 32'(exp_err));
    chk(ok == (exp_err == 0), "R9 ok flag", 32'(ok), 32'(exp_err == 0));
    if (mode == 0 || mode == 5) begin
      chk(big_endian == big, "R1 byte order flag", 32'(big_endian), 32'(big));
      chk(seg_count == hdr[1][31:16] && seg_index == hdr[1][15:0], "R3 segment fields",
          {seg_count, seg_index}, hdr[1]);
      bad = 0;
      for (int i = 0; i < iw; i++) if (imem_m[i] !== ivals[i]) bad++;
      for (int i = 0; i < dw; i++) if (dmem_m[i] !== dvals[i]) bad++;
      chk(bad == 0, big ? "R2 R8 stored words" : "R8 stored words", 32'(bad), 0);
      miss = 0;
      for (int i = 0; i < iw; i++) if (!iclr[i]) miss++;
      for (int i = 0; i < dw; i++) if (!dclr[i]) miss++;
      chk(miss == 0 && bad_clear == 0 && bad_order == 0, "R7 zero fill",
          32'(miss + bad_clear + bad_order), 0);
    end else begin
      chk(n_wr == 0, "R10 no writes on header error", 32'(n_wr), 0);
    end

    // extra offered words after done must be ignored
    bad = 0;
    @(posedge clk); #1; valid = 1; data = 32'hdead_beef;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (ready || !done || int'(err) != exp_err) bad++;
    end
    valid = 0;
    chk(bad == 0 && late_wr == 0, "R11 R10 hold after done", 32'(bad + late_wr), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; start = 0; valid = 0; data = 0; total_len = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ready && !done && !ok && err == 0 && !imem_we && !dmem_we, "R11 reset state",
        {26'd0, ready, done, ok, err[0], imem_we, dmem_we}, 0);
    @(posedge clk); #1; rst_n = 1;

    run_image(0, 3, 2, 0, 0);
    run_image(1, 4, 3, 0, 0);
    run_image(0, 0, 0, 0, 0);
    run_image(1, 0, 5, 0, 1);
    run_image(0, 6, 0, 0, 1);
    run_image(0, DEPTH, DEPTH, 0, 1);
    run_image(0, 2, 2, 1, 0);
    run_image(1, 2, 2, 2, 0);
    run_image(0, 2, 2, 3, 0);
    run_image(0, DEPTH + 1, 1, 4, 0);
    run_image(1, 3, DEPTH + 1, 4, 0);
    run_image(1, 5, 4, 5, 1);
    for (int r = 0; r < 8; r++)
      run_image(1'($urandom_range(0, 1)), $urandom_range(0, DEPTH), $urandom_range(0, DEPTH), 0, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule